// File: doc/BRIEF.md
# Dual-Clock Ping-Pong Frame Buffer

This block carries frames of samples from a producer running on one clock to a consumer running on an unrelated clock. Its storage holds two frames. The storage is split into two halves. The producer fills one half while the consumer drains the other. A half changes hands only after the side holding it declares its frame finished.

The producer writes words at a local index and pulses a frame-complete strobe. The consumer watches a frame-available output, and that output also serves as its clock-enable. The consumer reads words at a local index, gets data one read-clock cycle later, and pulses a release strobe when it is done with the frame. The two sides exchange frame counts in Gray code through a small synchronizer. No clock is ever gated.

A producer that completes a frame while the consumer still holds the other half raises an overflow flag. Its further writes and completions are dropped until the consumer frees a half.

Top module: `pingpong_frame_buf`

## Requirements
- R1: After reset, `rd_frame_rdy` is 0, `wr_overflow` is 0 and `rd_data` is 0. The producer fills half 0 first.
- R2: A frame completed with `wr_frame_done` while the producer is not blocked makes `rd_frame_rdy` go to 1 within a few read clocks. Reading local index i then returns the word written at index i of that frame on `rd_data`, one read-clock cycle after `rd_addr` is presented with `rd_en`.
- R3: A `wr_frame_done` taken while one frame is already waiting or being read sets `wr_overflow` at the next write clock edge. While `wr_overflow` is 1, writes and frame completions are discarded. `wr_overflow` returns to 0 a few write clocks after the consumer releases a frame.
- R4: Frames reach the consumer in the order they were completed, taken alternately from the two halves.
- R5: `rd_data` changes only on a read clock edge where `rd_en` is 1 and `rd_frame_rdy` is 1. Otherwise it holds its value.
- R6: `rd_release` has no effect while `rd_frame_rdy` is 0.
- R7: Writes into the producer's half in the same cycles as reads from the consumer's half corrupt neither frame.
- R8: After the consumer releases the last waiting frame, `rd_frame_rdy` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Producer clock |
| wr_rst | input | 1 | Producer-side synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | $clog2(FRAME_LEN) | Local index within the frame being written |
| wr_data | input | DATA_W | Sample to store |
| wr_frame_done | input | 1 | One-cycle pulse: producer has finished its frame |
| wr_overflow | output | 1 | Producer blocked; writes are dropped |
| rd_clk | input | 1 | Consumer clock |
| rd_rst | input | 1 | Consumer-side synchronous reset, active high |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | $clog2(FRAME_LEN) | Local index within the frame being read |
| rd_data | output | DATA_W | Read word, one cycle after the address |
| rd_release | input | 1 | One-cycle pulse: consumer has finished its frame |
| rd_frame_rdy | output | 1 | A frame is available; consumer clock-enable |

## Verification
The delicate case is the producer filling its half in the same cycles in which the consumer drains the other half. Both ports of the memory are then active on their own clocks, and the half bits must keep them apart. The bench forks a full frame write against a full frame read, and afterwards compares every word of both frames against the bench's queue of expected frames. A dropped write that leaked into a half would show up as a corrupted word in a later frame. The bench provokes such drops deliberately while the overflow flag is high.

// File: rtl/pp_pkg.sv
package pp_pkg;
  typedef logic [1:0] fcnt_t;

  function automatic fcnt_t to_gray(input fcnt_t b);
    return {b[1], b[1] ^ b[0]};
  endfunction

  function automatic fcnt_t from_gray(input fcnt_t g);
    return {g[1], g[1] ^ g[0]};
  endfunction
endpackage

// File: rtl/pp_sync.sv
module pp_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= din;
        else stage_q[s] <= stage_q[(s > 0) ? s - 1 : 0];
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/pp_dpram.sv
module pp_dpram #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 256,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rclk,
  input  logic              rrst,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (rrst) rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/pingpong_frame_buf.sv
module pingpong_frame_buf #(
  parameter int FRAME_LEN   = 128,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2,
  localparam int AW         = $clog2(FRAME_LEN)
) (
  input  logic              wr_clk,
  input  logic              wr_rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_frame_done,
  output logic              wr_overflow,
  input  logic              rd_clk,
  input  logic              rd_rst,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              rd_release,
  output logic              rd_frame_rdy
);
  import pp_pkg::*;

  localparam int DEPTH = 2 * FRAME_LEN;

  // producer domain
  fcnt_t w_gray, r_gray_at_w, w_bin, r_bin_at_w, pend_w;
  logic  full_w, block_w, ovf_q, ram_we;

  assign w_bin      = from_gray(w_gray);
  assign r_bin_at_w = from_gray(r_gray_at_w);
  assign pend_w     = w_bin - r_bin_at_w;
  assign full_w     = (pend_w == 2'd2);
  assign block_w    = full_w | ovf_q;
  assign ram_we     = wr_en & ~block_w;

  always_ff @(posedge wr_clk) begin
    if (wr_rst) begin
      w_gray <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (wr_frame_done && !block_w) w_gray <= to_gray(w_bin + 2'd1);
      if (wr_frame_done && !block_w && pend_w == 2'd1) ovf_q <= 1'b1;
      else if (!full_w) ovf_q <= 1'b0;
    end
  end

  assign wr_overflow = ovf_q;

  // consumer domain
  fcnt_t r_gray, w_gray_at_r, r_bin, pend_r;
  logic  rdy_r, ram_re;

  assign r_bin  = from_gray(r_gray);
  assign pend_r = from_gray(w_gray_at_r) - r_bin;
  assign rdy_r  = (pend_r != 2'd0);
  assign ram_re = rd_en & rdy_r;

  always_ff @(posedge rd_clk) begin
    if (rd_rst) r_gray <= '0;
    else if (rd_release && rdy_r) r_gray <= to_gray(r_bin + 2'd1);
  end

  assign rd_frame_rdy = rdy_r;

  // crossings: frame counts travel in Gray code
  pp_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wr_clk), .rst(wr_rst), .din(r_gray), .dout(r_gray_at_w)
  );
  pp_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rd_clk), .rst(rd_rst), .din(w_gray), .dout(w_gray_at_r)
  );

  pp_dpram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .wclk (wr_clk),
    .we   (ram_we),
    .waddr({w_bin[0], wr_addr}),
    .wdata(wr_data),
    .rclk (rd_clk),
    .rrst (rd_rst),
    .re   (ram_re),
    .raddr({r_bin[0], rd_addr}),
    .rdata(rd_data)
  );

  // producer never runs more than two frames ahead of the consumer (R3, R7)
  p_pend_bound_w_r3: assert property (@(posedge wr_clk) disable iff (wr_rst)
    pend_w <= 2'd2);
  // consumer never sees more than two frames waiting (R4)
  p_pend_bound_r_r4: assert property (@(posedge rd_clk) disable iff (rd_rst)
    pend_r <= 2'd2);
  // overflow only rises when the synchronized view shows both halves taken (R3)
  p_ovf_rise_full_r3: assert property (@(posedge wr_clk) disable iff (wr_rst)
    $rose(ovf_q) |-> full_w);
  // release with nothing ready leaves the consumer count alone (R6)
  p_release_idle_r6: assert property (@(posedge rd_clk) disable iff (rd_rst)
    !rdy_r |=> $stable(r_gray));
  // Gray counts move one bit at a time, as required for the crossing (R2)
  p_gray_step_w_r2: assert property (@(posedge wr_clk) disable iff (wr_rst)
    $countones(w_gray ^ $past(w_gray)) <= 1);
  p_gray_step_r_r8: assert property (@(posedge rd_clk) disable iff (rd_rst)
    $countones(r_gray ^ $past(r_gray)) <= 1);
endmodule

// File: tb/pingpong_frame_buf_test.sv
module pingpong_frame_buf_test;
  localparam int N  = 16;
  localparam int DW = 16;
  localparam int AW = $clog2(N);

  logic wr_clk = 0, rd_clk = 0;
  logic wr_rst = 1, rd_rst = 1;
  logic wr_en = 0, wr_frame_done = 0, rd_en = 0, rd_release = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic wr_overflow, rd_frame_rdy;

  int checks = 0, errors = 0;
  int q[$];
  bit finished = 0;

  always #4 wr_clk = ~wr_clk;
  always #7 rd_clk = ~rd_clk;

  pingpong_frame_buf #(.FRAME_LEN(N), .DATA_W(DW), .SYNC_STAGES(2)) uut (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_frame_done(wr_frame_done), .wr_overflow(wr_overflow),
    .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_release(rd_release), .rd_frame_rdy(rd_frame_rdy)
  );

  function automatic logic [DW-1:0] word(input int k, input int i);
    return DW'(k * 1000 + i * 7 + 5);
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // producer writes one frame then pulses completion; model tracks acceptance
  task automatic write_frame(input int k);
    bit take;
    take = (q.size() < 2) && !wr_overflow;
    for (int i = 0; i < N; i++) begin
      @(negedge wr_clk);
      wr_en = 1; wr_addr = AW'(i); wr_data = word(k, i);
    end
    @(negedge wr_clk);
    wr_en = 0; wr_frame_done = 1;
    @(negedge wr_clk);
    wr_frame_done = 0;
    if (take) q.push_back(k);
  endtask

  // consumer reads the oldest frame, compared every read clock
  task automatic read_frame(input string req);
    int k;
    k = q[0];
    for (int i = 0; i <= N; i++) begin
      @(negedge rd_clk);
      if (i > 0) chk(req, rd_data, word(k, i - 1));
      if (i < N) begin rd_en = 1; rd_addr = AW'(i); end
      else rd_en = 0;
    end
  endtask

  task automatic release_frame();
    @(negedge rd_clk);
    rd_release = 1;
    @(negedge rd_clk);
    rd_release = 0;
    if (q.size() > 0) void'(q.pop_front());
  endtask

  initial begin
    repeat (100000) @(posedge wr_clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge rd_clk);
    wr_rst = 0; rd_rst = 0;
    @(negedge rd_clk);
    chk("R1 rdy", rd_frame_rdy, 0);
    chk("R1 overflow", wr_overflow, 0);
    chk("R1 rd_data", rd_data, 0);

    // R5: read attempt with nothing ready must not move rd_data
    rd_en = 1; rd_addr = AW'(3);
    repeat (3) @(negedge rd_clk);
    chk("R5 hold idle", rd_data, 0);
    rd_en = 0;

    // R2: first frame becomes available
    write_frame(0);
    chk("R3 no overflow single", wr_overflow, 0);
    repeat (6) @(negedge rd_clk);
    chk("R2 rdy", rd_frame_rdy, 1);

    // R3: second completion while consumer holds frame 0
    write_frame(1);
    chk("R3 overflow set", wr_overflow, 1);
    write_frame(99);
    chk("R3 overflow held", wr_overflow, 1);

    read_frame("R2 frame0 data");
    release_frame();
    repeat (10) @(negedge wr_clk);
    chk("R3 overflow clear", wr_overflow, 0);
    chk("R4 next ready", rd_frame_rdy, 1);

    // R7: fill half 0 while draining half 1
    fork
      write_frame(2);
      read_frame("R7 R4 frame1 data");
    join
    release_frame();
    repeat (6) @(negedge rd_clk);
    chk("R4 frame2 ready", rd_frame_rdy, 1);
    read_frame("R7 frame2 data");
    release_frame();
    repeat (2) @(negedge rd_clk);
    chk("R8 rdy low", rd_frame_rdy, 0);

    // R6: stray release while idle must not eat the next frame
    release_frame();
    write_frame(3);
    repeat (6) @(negedge rd_clk);
    chk("R6 rdy after stray release", rd_frame_rdy, 1);
    read_frame("R6 frame3 data");
    release_frame();
    repeat (2) @(negedge rd_clk);
    chk("R8 rdy low again", rd_frame_rdy, 0);

    // R5: reads while idle hold the last word
    rd_en = 1; rd_addr = AW'(0);
    repeat (3) @(negedge rd_clk);
    chk("R5 hold after frame", rd_data, word(3, N - 1));
    rd_en = 0;
    chk("R4 model empty", q.size(), 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule